// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a ring of transmit descriptors held in system memory and turns the buffers they point at into a byte stream. A poll pulse starts a walk at the current ring pointer. For each descriptor that software has handed over, the walker reads it through a simple word-wide memory port and checks its sizes. It then streams the first buffer out over a valid/ready byte interface, marking the final byte of a frame. Finally it hands the descriptor back to software by clearing its ownership flag in memory and moves to the next ring slot.

Each descriptor takes 32 bytes (eight words) at a 32-byte step:
- word 0 is the control/status word;
- word 1 holds the two 12-bit buffer lengths (first buffer in bits 11:0, second in bits 27:16);
- word 2 is the first buffer's byte address.

The memory port returns read data exactly one cycle after a read request. A walk ends at the first descriptor the walker does not own, or at the first one whose sizes are unacceptable. In that case the descriptor is left untouched in memory and the pointer stays on it, so the next poll resumes there.

Top module: `txring_walker`

## Requirements
- R1: While `rst_n` is low at a clock edge, and until the next accepted command, `busy`, `tx_valid`, `mem_req`, `irq_tx_done` and `irq_summary` are 0 and `cur_ptr` is 0.
- R2: A `base_load` pulse seen while idle sets both the stored ring base and `cur_ptr` to `tx_base`. A `base_load` seen while `busy` is high has no effect on either.
- R3: A `poll_start` pulse seen while idle raises `busy` on the next cycle. `busy` stays high until the walk ends. A `poll_start` seen while busy has no effect.
- R4: A descriptor whose control word has bit 31 (ownership) clear ends the walk. No bytes are sent, nothing is written, and `cur_ptr` is unchanged.
- R5: For an accepted descriptor, the number of bytes sent equals the length in word 1 bits 11:0; size bits 15:12 are ignored. The bytes start at the byte address in word 2, at any alignment, and go in ascending address order. Within a memory word, byte k sits in bits 8k+7:8k.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R7: When control bit 29 (last segment) is set, `tx_last` marks the final byte of that descriptor's buffer. `irq_tx_done` and `irq_summary` then pulse together for one cycle when that descriptor is written back. No other byte carries `tx_last`.
- R8: After its buffer has been sent, a descriptor's control word is written back to its own address with bit 31 cleared and every other bit unchanged. This is the only memory write the walker makes.
- R9: After the write-back, `cur_ptr` reloads the ring base if control bit 21 (end of ring) is set, and otherwise advances by 32. The walk then goes on with the descriptor at the new `cur_ptr`.
- R10: A descriptor with a first-buffer length above 2048, or with any nonzero bit in word 1 bits 27:16, ends the walk. No bytes are sent, nothing is written, and `cur_ptr` is unchanged. A length of exactly 2048 is accepted.
- R11: The walker keeps the running byte count of the current frame. It clears the count at each poll and after each last-segment descriptor. If the count plus a descriptor's length reaches 8192 or more, that descriptor ends the walk as in R10.
- R12: An owned descriptor with zero length sends no bytes but is still written back and advanced past. It also raises the completion pulses if it is a last segment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_start | input | 1 | Start-walk pulse |
| base_load | input | 1 | Load ring base and current pointer from `tx_base` |
| tx_base | input | AW | Ring base byte address |
| busy | output | 1 | A walk is in progress |
| cur_ptr | output | AW | Byte address of the current descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word-aligned byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| tx_valid | output | 1 | Byte stream valid |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Byte stream consumer ready |
| irq_tx_done | output | 1 | Frame completed pulse |
| irq_summary | output | 1 | Normal summary pulse, paired with `irq_tx_done` |

## Verification
The bench targets the size boundaries:
- A 2048-byte buffer must be sent, while 2049 bytes or a stray second-buffer length must stop the walk with no write-back. A comparator that is off by one would stream a bad buffer or refuse a legal one.
- A chain of 2048-byte fragments must stop exactly where the frame count reaches 8192. A walker that fails to clear the count after a last segment would stop two descriptors early.

It also checks the end-of-ring reload, which must stop at the now-released first slot instead of running off the ring. It streams an unaligned buffer, where a wrong byte-lane select scrambles the data, and a zero-length descriptor, which must still be released. Throughout, the consumer stalls the stream regularly, and the bench checks that every stalled byte is held steady.

// File: rtl/txw_pkg.sv
package txw_pkg;
    // Control word bit positions; software decodes these, so they are fixed.
    localparam int OWN_BIT    = 31;
    localparam int LAST_BIT   = 29;
    localparam int EOR_BIT    = 21;
    // Descriptor geometry.
    localparam int WORD_W     = 32;
    localparam int DESC_BYTES = 32;
    localparam int SIZE2_LSB  = 16;

    typedef enum logic [3:0] {
        W_IDLE,
        W_FETCH_CTL,
        W_CAP_CTL,
        W_FETCH_SIZE,
        W_CAP_SIZE,
        W_FETCH_ADDR,
        W_CAP_ADDR,
        W_CHECK,
        W_STREAM,
        W_WBACK
    } walk_state_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_CAP,
        S_EMIT
    } strm_state_t;
endpackage

// File: rtl/txw_desc_check.sv
// Descriptor size checker.
// Decides whether the fetched descriptor may be processed. It flags a
// malformed size pair and a frame that would grow past the frame limit.
// Assumes frame_bytes is always below MAX_FRAME.
module txw_desc_check #(
    parameter int LEN_W     = 12,
    parameter int MAX_BUF   = 2048,
    parameter int MAX_FRAME = 8192,
    parameter int FW        = 13
) (
    input  logic [LEN_W-1:0] len1,
    input  logic [LEN_W-1:0] len2,
    input  logic [FW-1:0]    frame_bytes,
    output logic             bad_size,
    output logic             frame_full
);
    localparam int SW = FW + 1;

    logic [SW-1:0] sum;

    // Size legality and frame-limit comparison.
    always_comb begin
        bad_size   = (len1 > LEN_W'(MAX_BUF)) || (len2 != '0);
        sum        = {1'b0, frame_bytes} + SW'(len1);
        frame_full = (sum >= SW'(MAX_FRAME));
    end
endmodule

// File: rtl/txw_ring_ptr.sv
// Ring pointer holder.
// Keeps the ring base and the current descriptor pointer. A load sets both.
// A step either wraps to the base or moves on by one descriptor.
// Assumes load and step never coincide (the caller gates load on idle).
module txw_ring_ptr #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base_in,
    input  logic          step,
    input  logic          wrap,
    output logic [AW-1:0] cur_ptr
);
    logic [AW-1:0] base_q;

    // Base and current pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            cur_ptr <= '0;
        end else if (load) begin
            base_q  <= base_in;
            cur_ptr <= base_in;
        end else if (step) begin
            cur_ptr <= wrap ? base_q : cur_ptr + AW'(DESC_BYTES);
        end
    end
endmodule

// File: rtl/txw_byte_streamer.sv
// Buffer-to-byte-stream engine.
// Reads a buffer word by word (one-cycle read latency) and emits its bytes in
// ascending address order over valid/ready. It handles any start alignment.
// Assumes start is only pulsed while idle.
module txw_byte_streamer
    import txw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              mark_last,
    output logic              done,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    strm_state_t       st_q;
    logic [AW-1:0]     addr_q;
    logic [LEN_W-1:0]  left_q;
    logic [WORD_W-1:0] word_q;
    logic              last_q;
    logic              final_byte;

    // Output decode from state and counters.
    always_comb begin
        final_byte = (left_q == LEN_W'(1));
        mem_req    = (st_q == S_REQ) && (left_q != '0);
        mem_addr   = {addr_q[AW-1:2], 2'b00};
        tx_valid   = (st_q == S_EMIT);
        tx_data    = word_q[{addr_q[1:0], 3'b000} +: 8];
        tx_last    = tx_valid && last_q && final_byte;
        done       = ((st_q == S_EMIT) && tx_ready && final_byte) ||
                     ((st_q == S_REQ) && (left_q == '0));
    end

    // Fetch/emit sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            addr_q <= '0;
            left_q <= '0;
            word_q <= '0;
            last_q <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (start) begin
                        addr_q <= start_addr;
                        left_q <= start_len;
                        last_q <= mark_last;
                        st_q   <= S_REQ;
                    end
                end
                S_REQ: begin
                    st_q <= (left_q == '0) ? S_IDLE : S_CAP;
                end
                S_CAP: begin
                    word_q <= mem_rdata;
                    st_q   <= S_EMIT;
                end
                S_EMIT: begin
                    if (tx_ready) begin
                        addr_q <= addr_q + AW'(1);
                        left_q <= left_q - LEN_W'(1);
                        if (final_byte) begin
                            st_q <= S_IDLE;
                        end else if (addr_q[1:0] == 2'b11) begin
                            st_q <= S_REQ;
                        end
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R6: a stalled byte is held unchanged.
    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R7: tx_last only accompanies a valid byte.
    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
endmodule

// File: rtl/txring_walker.sv
// Transmit descriptor ring walker (top).
// On a poll it fetches descriptors at the current pointer and validates them.
// It streams the first buffer of each, releases the descriptor by clearing its
// ownership bit in memory, and advances or wraps the ring pointer.
// Assumes a memory that returns read data one cycle after the request.
module txring_walker
    import txw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LEN_W     = 12,
    parameter int MAX_BUF   = 2048,
    parameter int MAX_FRAME = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_start,
    input  logic              base_load,
    input  logic [AW-1:0]     tx_base,
    output logic              busy,
    output logic [AW-1:0]     cur_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              irq_tx_done,
    output logic              irq_summary
);
    localparam int FW = $clog2(MAX_FRAME);
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;

    walk_state_t       st_q;
    logic [WORD_W-1:0] ctl_q;
    logic [LEN_W-1:0]  len1_q;
    logic [LEN_W-1:0]  len2_q;
    logic [AW-1:0]     bufa_q;
    logic [FW-1:0]     frame_q;

    logic              bad_size;
    logic              frame_full;
    logic              reject;
    logic              s_start;
    logic              s_done;
    logic              s_req;
    logic [AW-1:0]     s_addr;
    logic              wb_cycle;

    txw_desc_check #(
        .LEN_W     (LEN_W),
        .MAX_BUF   (MAX_BUF),
        .MAX_FRAME (MAX_FRAME),
        .FW        (FW)
    ) u_check (
        .len1        (len1_q),
        .len2        (len2_q),
        .frame_bytes (frame_q),
        .bad_size    (bad_size),
        .frame_full  (frame_full)
    );

    txw_ring_ptr #(
        .AW         (AW),
        .DESC_BYTES (DESC_BYTES)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (base_load && (st_q == W_IDLE)),
        .base_in (tx_base),
        .step    (wb_cycle),
        .wrap    (ctl_q[EOR_BIT]),
        .cur_ptr (cur_ptr)
    );

    txw_byte_streamer #(
        .AW    (AW),
        .LEN_W (LEN_W)
    ) u_strm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (s_start),
        .start_addr (bufa_q),
        .start_len  (len1_q),
        .mark_last  (ctl_q[LAST_BIT]),
        .done       (s_done),
        .mem_req    (s_req),
        .mem_addr   (s_addr),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready)
    );

    // Walk-level control decode.
    always_comb begin
        busy        = (st_q != W_IDLE);
        reject      = bad_size || frame_full;
        s_start     = (st_q == W_CHECK) && !reject && (len1_q != '0);
        wb_cycle    = (st_q == W_WBACK);
        irq_tx_done = wb_cycle && ctl_q[LAST_BIT];
        irq_summary = wb_cycle && ctl_q[LAST_BIT];
    end

    // Memory port arbitration between descriptor access and the streamer.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = ctl_q & ~OWN_MASK;
        case (st_q)
            W_FETCH_CTL:  mem_req = 1'b1;
            W_FETCH_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + AW'(4);
            end
            W_FETCH_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + AW'(8);
            end
            W_STREAM: begin
                mem_req  = s_req;
                mem_addr = s_addr;
            end
            W_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // Descriptor walk sequencing and frame byte accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= W_IDLE;
            ctl_q   <= '0;
            len1_q  <= '0;
            len2_q  <= '0;
            bufa_q  <= '0;
            frame_q <= '0;
        end else begin
            case (st_q)
                W_IDLE: begin
                    if (poll_start) begin
                        frame_q <= '0;
                        st_q    <= W_FETCH_CTL;
                    end
                end
                W_FETCH_CTL: st_q <= W_CAP_CTL;
                W_CAP_CTL: begin
                    ctl_q <= mem_rdata;
                    st_q  <= mem_rdata[OWN_BIT] ? W_FETCH_SIZE : W_IDLE;
                end
                W_FETCH_SIZE: st_q <= W_CAP_SIZE;
                W_CAP_SIZE: begin
                    len1_q <= mem_rdata[LEN_W-1:0];
                    len2_q <= mem_rdata[SIZE2_LSB +: LEN_W];
                    st_q   <= W_FETCH_ADDR;
                end
                W_FETCH_ADDR: st_q <= W_CAP_ADDR;
                W_CAP_ADDR: begin
                    bufa_q <= mem_rdata[AW-1:0];
                    st_q   <= W_CHECK;
                end
                W_CHECK: begin
                    if (reject) begin
                        st_q <= W_IDLE;
                    end else if (len1_q == '0) begin
                        st_q <= W_WBACK;
                    end else begin
                        st_q <= W_STREAM;
                    end
                end
                W_STREAM: begin
                    if (s_done) begin
                        st_q <= W_WBACK;
                    end
                end
                W_WBACK: begin
                    frame_q <= ctl_q[LAST_BIT] ? '0 : frame_q + FW'(len1_q);
                    st_q    <= W_FETCH_CTL;
                end
                default: st_q <= W_IDLE;
            endcase
        end
    end

    // R8: every write releases ownership.
    a_r8_wb_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

    // R3: no memory or stream activity while idle.
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !tx_valid));

    // R3: a walk only begins after a poll.
    a_r3_busy_from_poll: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(poll_start));

    // R7: completion pulses only accompany a write-back.
    a_r7_irq_at_wb: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_done |-> (mem_we && irq_summary));

    // R2: pointer is left alone while a load arrives during a walk without a step.
    a_r2_load_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && base_load && !mem_we) |=> $stable(cur_ptr));
endmodule

// File: tb/txring_walker_bench.sv
module txring_walker_bench;
    localparam int AW = 32;
    localparam logic [31:0] BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_start = 1'b0;
    logic        base_load = 1'b0;
    logic [31:0] tx_base = '0;
    logic        busy;
    logic [31:0] cur_ptr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        irq_tx_done, irq_summary;

    int checks = 0;
    int fails = 0;

    txring_walker #(.AW(AW)) u_txring_walker (
        .clk(clk), .rst_n(rst_n), .poll_start(poll_start), .base_load(base_load),
        .tx_base(tx_base), .busy(busy), .cur_ptr(cur_ptr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .irq_tx_done(irq_tx_done),
        .irq_summary(irq_summary)
    );

    always #5 clk = ~clk;

    // Memory model: 4 KiB, one-cycle read latency.
    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    // Monitor state.
    logic [7:0]  got [0:16383];
    int          nbytes, last_cnt, last_pos, wb_cnt, irq_cnt, sum_cnt, stall_bad, cyc;
    logic [31:0] wb_data, wb_addr;
    logic        prev_stall = 1'b0;
    logic [7:0]  prev_data;
    logic        prev_last;

    task automatic clear_mon();
        nbytes = 0; last_cnt = 0; last_pos = -1; wb_cnt = 0;
        irq_cnt = 0; sum_cnt = 0; wb_data = '0; wb_addr = '0;
    endtask

    always @(negedge clk) begin
        cyc <= cyc + 1;
        tx_ready = (cyc % 5) != 2;
        if (prev_stall) begin
            if (!tx_valid || tx_data != prev_data || tx_last != prev_last)
                stall_bad++;
        end
        if (tx_valid && tx_ready) begin
            got[nbytes] = tx_data;
            if (tx_last) begin last_cnt++; last_pos = nbytes; end
            nbytes++;
        end
        prev_stall = tx_valid && !tx_ready;
        prev_data  = tx_data;
        prev_last  = tx_last;
        if (mem_req && mem_we) begin wb_cnt++; wb_data = mem_wdata; wb_addr = mem_addr; end
        if (irq_tx_done) irq_cnt++;
        if (irq_summary) sum_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_base(input logic [31:0] b);
        @(negedge clk); tx_base = b; base_load = 1'b1;
        @(negedge clk); base_load = 1'b0;
    endtask

    task automatic put_desc(input int slot, input logic [31:0] c, input logic [31:0] s,
                            input logic [31:0] b);
        mem[(BASE >> 2) + 8 * slot]     = c;
        mem[(BASE >> 2) + 8 * slot + 1] = s;
        mem[(BASE >> 2) + 8 * slot + 2] = b;
    endtask

    task automatic run_walk();
        @(negedge clk); poll_start = 1'b1;
        @(negedge clk); poll_start = 1'b0;
        for (int i = 0; i < 60000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    // Rows: ctl, size word, buffer address, bytes, processed, irq, pointer offset.
    localparam logic [127:0] ROWS [0:7] = '{
        {32'hA000_0055, 32'h0000_F00A, 32'h0000_0400, 16'd10,   4'd1, 4'd1, 8'd32}, // R5 R7 R9
        {32'hA020_0000, 32'h0000_0005, 32'h0000_0403, 16'd5,    4'd1, 4'd1, 8'd0},  // R9 wrap, unaligned
        {32'h2000_0000, 32'h0000_0008, 32'h0000_0400, 16'd0,    4'd0, 4'd0, 8'd0},  // R4
        {32'h8000_0000, 32'h0000_0801, 32'h0000_0400, 16'd0,    4'd0, 4'd0, 8'd0},  // R10 2049
        {32'hA000_0000, 32'h0000_0800, 32'h0000_0800, 16'd2048, 4'd1, 4'd1, 8'd32}, // R10 2048 ok
        {32'hA000_0000, 32'h0004_0004, 32'h0000_0400, 16'd0,    4'd0, 4'd0, 8'd0},  // R10 size2
        {32'hA000_0000, 32'h0000_0000, 32'h0000_0400, 16'd0,    4'd1, 4'd1, 8'd32}, // R12
        {32'h8000_0000, 32'h0000_0007, 32'h0000_0401, 16'd7,    4'd1, 4'd0, 8'd32}  // R7 not last
    };

    initial begin
        #1_900_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cyc = 0; stall_bad = 0;
        for (int w = 0; w < 1024; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        clear_mon();
        do_reset();
        // R1 reset state
        chk(!busy && !tx_valid && !mem_req, "R1 idle outputs", {busy, tx_valid, mem_req}, 0);
        chk(!irq_tx_done && !irq_summary, "R1 irq low", {irq_tx_done, irq_summary}, 0);
        chk(cur_ptr == 0, "R1 cur_ptr", cur_ptr, 0);

        for (int r = 0; r < 8; r++) begin
            logic [31:0] c, s, b;
            int n, pr, iq, off, mism;
            c = ROWS[r][127:96]; s = ROWS[r][95:64]; b = ROWS[r][63:32];
            n = int'(ROWS[r][31:16]); pr = int'(ROWS[r][15:12]);
            iq = int'(ROWS[r][11:8]); off = int'(ROWS[r][7:0]);
            do_reset();
            put_desc(0, c, s, b);
            put_desc(1, 32'h0, 32'h0, 32'h0);
            load_base(BASE);
            chk(cur_ptr == BASE, "R2 idle load", cur_ptr, BASE);
            clear_mon();
            run_walk();
            chk(!busy, "R3 busy falls", busy, 0);
            chk(nbytes == n, "R5 byte count", nbytes, n);
            mism = 0;
            for (int i = 0; i < n; i++) if (got[i] != pat(int'(b) + i)) mism++;
            chk(mism == 0, "R5 byte content", mism, 0);
            chk(last_cnt == ((iq != 0 && n > 0) ? 1 : 0), "R7 last count", last_cnt,
                (iq != 0 && n > 0) ? 1 : 0);
            if (iq != 0 && n > 0) chk(last_pos == n - 1, "R7 last position", last_pos, n - 1);
            chk(irq_cnt == iq && sum_cnt == iq, "R7 irq pulses", irq_cnt, iq);
            chk(wb_cnt == pr, "R8 writeback count", wb_cnt, pr);
            if (pr != 0) begin
                chk(wb_data == (c & 32'h7FFF_FFFF), "R8 writeback data", wb_data, c & 32'h7FFF_FFFF);
                chk(wb_addr == BASE, "R8 writeback addr", wb_addr, BASE);
            end
            chk(cur_ptr == BASE + off, "R9 pointer", cur_ptr, BASE + off);
        end

        // R11 chain: frame of two, then fragments until the 8192 limit.
        do_reset();
        put_desc(0, 32'h8000_0000, 32'h0000_0800, 32'h800);
        put_desc(1, 32'hA000_0000, 32'h0000_0800, 32'h800);
        put_desc(2, 32'h8000_0000, 32'h0000_0800, 32'h800);
        put_desc(3, 32'h8000_0000, 32'h0000_0800, 32'h800);
        put_desc(4, 32'h8000_0000, 32'h0000_0800, 32'h800);
        put_desc(5, 32'h8000_0000, 32'h0000_0800, 32'h800);
        put_desc(6, 32'h0, 32'h0, 32'h0);
        load_base(BASE);
        clear_mon();
        @(negedge clk); poll_start = 1'b1;
        @(negedge clk); poll_start = 1'b0;
        repeat (50) @(negedge clk);
        tx_base = 32'h300; base_load = 1'b1; poll_start = 1'b1;  // R2 R3 while busy
        @(negedge clk); base_load = 1'b0; poll_start = 1'b0;
        for (int i = 0; i < 60000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        chk(wb_cnt == 5, "R11 fragments released", wb_cnt, 5);
        chk(nbytes == 10240, "R11 bytes sent", nbytes, 10240);
        chk(cur_ptr == BASE + 32'd160, "R2 load ignored while busy", cur_ptr, BASE + 32'd160);
        chk(irq_cnt == 1 && last_cnt == 1, "R7 one frame end", irq_cnt, 1);
        repeat (20) @(negedge clk);
        chk(!busy && wb_cnt == 5, "R3 start ignored while busy", wb_cnt, 5);
        chk(stall_bad == 0, "R6 stalled byte held", stall_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule